// File: doc/BRIEF.md
# Multi-Bank SDRAM State Tracker

This block watches the command pins of an SDRAM device, one command per rising clock edge. It keeps a small state machine for each bank, so a memory controller or a protocol monitor can see which banks are closed, opening, open, bursting or closing. Each bank also has its row-cycle, RAS-to-CAS, active-to-precharge, write-recovery and precharge windows timed in clock cycles. Every bank reports the row it last opened.

Commands that break the bank rules are flagged on a one-cycle pulse that carries the bank concerned, and they have no effect on any tracked state. The block also reports whether every bank is closed with no refresh in flight. Refresh logic can use that flag to decide when an auto-refresh may be issued.

The burst length comes from a mode input. A bit in the address selects auto-precharge on a read or write, and all-bank scope on a precharge. With auto-precharge, the bank closes by itself after a delay taken from the burst length.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads idle (state code 0), `all_idle_o` is 1 and `illegal_o` is 0. Bank states are packed 3 bits per bank in `bank_state_o`, bank b at bits [3b+2:3b], with codes idle 0, opening 1, open 2, reading 3, writing 4, closing 5. The state shown in a cycle is the one that applies to a command sampled at the next rising edge.
- R2: Commands are decoded from {ras_n,cas_n,we_n} while cs_n is low: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. cs_n high is a no-op. An activate to an idle bank latches the address as that bank's row in `open_row_o` (bank b at bits [ROW_W*b+ROW_W-1:ROW_W*b]). The bank then reads opening for T_RCD-1 cycles and open after that.
- R3: An activate to a bank that is not idle, or one sampled fewer than T_RC edges after the previous activate to that bank, is illegal. The bank's state and row do not change.
- R4: A read or write sampled fewer than T_RCD edges after the activate of its bank is illegal.
- R5: A read with address bit 10 set closes its bank by itself. An activate to that bank becomes legal exactly BL+T_RP edges after the read, and no earlier than T_RC edges after the bank's activate. BL is 1<<bl_code_i[1:0] when bl_code_i[2] is 0.
- R6: A write with address bit 10 set becomes legal to re-activate exactly BL-1+T_WR+T_RP edges after the write, subject to the same T_RC limit.
- R7: bl_code_i[2]=1 selects full page. A read or write with bit 10 set is then illegal. A full-page read stays in the reading state until a precharge.
- R8: A precharge to an open bank sampled fewer than T_RAS edges after its activate is illegal. A legal one shows closing, and the bank shows idle T_RP edges later. A read without auto-precharge shows open again BL edges after the read.
- R9: A precharge with address bit 10 set applies to all banks. If any bank may not be precharged, the whole command is ignored and `illegal_bank_o` gives the lowest such bank.
- R10: Refresh and mode set are legal only while `all_idle_o` is 1. After a refresh, `all_idle_o` reads 0, and every command other than no-op or deselect is illegal until T_RC edges have passed.
- R11: `illegal_o` is high for exactly the one cycle after the edge that sampled an illegal command, with `illegal_bank_o` naming the bank concerned. It is never raised for a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_i | input | BA_W | Bank address |
| addr_i | input | ROW_W | Address; row on activate, bit 10 as option flag otherwise |
| bl_code_i | input | 3 | Burst length code: 0..3 give 1,2,4,8; bit 2 set gives full page |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state codes |
| open_row_o | output | ROW_W*NUM_BANKS | Per-bank latched row |
| all_idle_o | output | 1 | All banks idle and no refresh in progress |
| illegal_o | output | 1 | One-cycle pulse for a rejected command |
| illegal_bank_o | output | BA_W | Bank the rejected command concerned |

## Verification
The rejection pulse appears in the cycle after the edge that samples the command. The state view is already the lookahead for the next edge. The bench therefore drives each command on a falling edge and reads both outputs at the next falling edge. Every timing window is swept across its boundary by placing a probe command k no-ops after the opening command. Legality is predicted from the edge distance: k+1 for adjacent commands, and the total offset from the activate for the T_RC bound. The sweeps also cover every short burst length, and both reads and writes with auto-precharge.

// File: rtl/sdram_bt_pkg.sv
package sdram_bt_pkg;

   typedef enum logic [2:0] {
      BS_IDLE    = 3'd0,
      BS_OPENING = 3'd1,
      BS_OPEN    = 3'd2,
      BS_READ    = 3'd3,
      BS_WRITE   = 3'd4,
      BS_CLOSING = 3'd5
   } bank_st_e;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS,
      CMD_STOP
   } cmd_e;

   localparam int BLC_W       = 3;
   localparam int BL_LOG2_MAX = 3;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_bt_decode.sv
module sdram_bt_decode
   import sdram_bt_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BLC_W-1:0] bl_code_i,
   output cmd_e             cmd_o,
   output logic             is_op_o,
   output logic             full_page_o,
   output logic [CNT_W-1:0] bl_cycles_o
);

   if (CNT_W < BL_LOG2_MAX + 1) begin : g_bad_cnt_w
      $error("counter too narrow for the longest burst");
   end

   always_comb begin
      if (cs_n) begin
         cmd_o = CMD_NOP;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            3'b000:  cmd_o = CMD_MRS;
            3'b110:  cmd_o = CMD_STOP;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end

   assign is_op_o     = (cmd_o != CMD_NOP);
   assign full_page_o = bl_code_i[BLC_W-1];
   assign bl_cycles_o = CNT_W'(1) << bl_code_i[1:0];

endmodule

// File: rtl/sdram_bt_refresh.sv
module sdram_bt_refresh #(
   parameter int T_RC  = 9,
   parameter int CNT_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   if (T_RC < 2) begin : g_bad_trc
      $error("T_RC must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(T_RC - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   assert_ref_only_when_free_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

   assert_ref_window_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

endmodule

// File: rtl/sdram_bt_bank.sv
module sdram_bt_bank
   import sdram_bt_pkg::*;
#(
   parameter int T_RCD = 3,
   parameter int T_RP  = 3,
   parameter int T_RAS = 6,
   parameter int T_RC  = 9,
   parameter int T_WR  = 2,
   parameter int ROW_W = 12,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act_i,
   input  logic             do_rd_i,
   input  logic             do_wr_i,
   input  logic             do_pre_i,
   input  logic             auto_pre_i,
   input  logic             full_page_i,
   input  logic [CNT_W-1:0] bl_cycles_i,
   input  logic [ROW_W-1:0] row_i,
   output bank_st_e         state_o,
   output logic             can_act_o,
   output logic             can_rw_o,
   output logic             can_pre_o,
   output logic [ROW_W-1:0] row_o
);

   bank_st_e         st_q, st_eff;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rc_q;
   logic [CNT_W-1:0] ras_q;
   logic             ap_q, fp_q;
   logic [ROW_W-1:0] row_q;
   logic             timed, endless, done, open_like;

   assign timed   = (st_q == BS_OPENING) || (st_q == BS_READ) ||
                    (st_q == BS_WRITE)   || (st_q == BS_CLOSING);
   assign endless = fp_q && ((st_q == BS_READ) || (st_q == BS_WRITE));
   assign done    = timed && !endless && (cnt_q == '0);

   always_comb begin
      st_eff = st_q;
      if (done) begin
         unique case (st_q)
            BS_OPENING:        st_eff = BS_OPEN;
            BS_READ, BS_WRITE: st_eff = ap_q ? BS_CLOSING : BS_OPEN;
            BS_CLOSING:        st_eff = BS_IDLE;
            default:           st_eff = st_q;
         endcase
      end
   end

   assign open_like = (st_eff == BS_OPEN) || (st_eff == BS_READ) || (st_eff == BS_WRITE);

   assign can_act_o = (st_eff == BS_IDLE) && (rc_q == '0);
   assign can_rw_o  = (st_eff == BS_OPEN) ||
                      (((st_eff == BS_READ) || (st_eff == BS_WRITE)) && !ap_q);
   assign can_pre_o = (st_eff == BS_IDLE) || (st_eff == BS_CLOSING) ||
                      ((ras_q == '0) && ((st_eff == BS_OPEN) ||
                                         ((st_eff == BS_READ) && !ap_q) ||
                                         ((st_eff == BS_WRITE) && fp_q)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= BS_IDLE;
         cnt_q <= '0;
         rc_q  <= '0;
         ras_q <= '0;
         ap_q  <= 1'b0;
         fp_q  <= 1'b0;
         row_q <= '0;
      end else begin
         if (rc_q != '0)  rc_q  <= rc_q - 1'b1;
         if (ras_q != '0) ras_q <= ras_q - 1'b1;
         if (do_act_i) begin
            st_q  <= BS_OPENING;
            cnt_q <= CNT_W'(T_RCD - 1);
            rc_q  <= CNT_W'(T_RC - 1);
            ras_q <= CNT_W'(T_RAS - 1);
            row_q <= row_i;
            ap_q  <= 1'b0;
            fp_q  <= 1'b0;
         end else if (do_rd_i) begin
            st_q  <= BS_READ;
            cnt_q <= bl_cycles_i - 1'b1;
            ap_q  <= auto_pre_i;
            fp_q  <= full_page_i;
         end else if (do_wr_i) begin
            st_q  <= BS_WRITE;
            cnt_q <= bl_cycles_i + CNT_W'(T_WR) - CNT_W'(2);
            ap_q  <= auto_pre_i;
            fp_q  <= full_page_i;
         end else if (do_pre_i && open_like) begin
            st_q  <= BS_CLOSING;
            cnt_q <= CNT_W'(T_RP - 1);
            ap_q  <= 1'b0;
            fp_q  <= 1'b0;
         end else begin
            st_q <= st_eff;
            if (done && (st_eff == BS_CLOSING)) begin
               cnt_q <= CNT_W'(T_RP - 1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
            if (done) begin
               ap_q <= 1'b0;
               fp_q <= 1'b0;
            end
         end
      end
   end

   assign state_o = st_eff;
   assign row_o   = row_q;

   assert_act_only_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      do_act_i |-> (st_eff == BS_IDLE) && (rc_q == '0));

   assert_idle_left_by_act_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ((st_eff == BS_IDLE) && !do_act_i) |=> (st_eff == BS_IDLE));

   assert_rw_after_rcd_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd_i || do_wr_i) |-> (st_eff != BS_OPENING) && (st_eff != BS_IDLE));

   assert_pre_after_ras_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (do_pre_i && open_like) |-> (ras_q == '0));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sdram_bt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_RC      = 9,
   parameter int T_WR      = 2,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            bank_i,
   input  logic [ROW_W-1:0]           addr_i,
   input  logic [BLC_W-1:0]           bl_code_i,
   output logic [3*NUM_BANKS-1:0]     bank_state_o,
   output logic [ROW_W*NUM_BANKS-1:0] open_row_o,
   output logic                       all_idle_o,
   output logic                       illegal_o,
   output logic [BA_W-1:0]            illegal_bank_o
);

   localparam int MAX_D = imax(imax(imax(T_RC, T_RAS), imax(T_RCD, T_RP)),
                               (1 << BL_LOG2_MAX) + T_WR);
   localparam int CNT_W = $clog2(MAX_D + 1);

   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (ROW_W < 11) begin : g_bad_row
      $error("ROW_W must cover address bit 10");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RAS < 1 || T_WR < 1) begin : g_bad_timing
      $error("timing parameters must be at least one cycle");
   end

   cmd_e             cmd;
   logic             is_op, full_page, opt_bit, ref_busy, ref_start;
   logic [CNT_W-1:0] bl_cycles;

   sdram_bt_decode #(.CNT_W(CNT_W)) u_decode (
      .cs_n        (cs_n),
      .ras_n       (ras_n),
      .cas_n       (cas_n),
      .we_n        (we_n),
      .bl_code_i   (bl_code_i),
      .cmd_o       (cmd),
      .is_op_o     (is_op),
      .full_page_o (full_page),
      .bl_cycles_o (bl_cycles)
   );

   assign opt_bit = addr_i[10];

   sdram_bt_refresh #(.T_RC(T_RC), .CNT_W(CNT_W)) u_refresh (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (ref_start),
      .busy_o  (ref_busy)
   );

   bank_st_e             bank_st [NUM_BANKS];
   logic [NUM_BANKS-1:0] can_act, can_rw, can_pre, bank_idle;
   logic [NUM_BANKS-1:0] act_v, rd_v, wr_v, pre_v, sel;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      sdram_bt_bank #(
         .T_RCD (T_RCD), .T_RP (T_RP), .T_RAS (T_RAS), .T_RC (T_RC),
         .T_WR  (T_WR),  .ROW_W(ROW_W), .CNT_W(CNT_W)
      ) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .do_act_i    (act_v[g]),
         .do_rd_i     (rd_v[g]),
         .do_wr_i     (wr_v[g]),
         .do_pre_i    (pre_v[g]),
         .auto_pre_i  (opt_bit),
         .full_page_i (full_page),
         .bl_cycles_i (bl_cycles),
         .row_i       (addr_i),
         .state_o     (bank_st[g]),
         .can_act_o   (can_act[g]),
         .can_rw_o    (can_rw[g]),
         .can_pre_o   (can_pre[g]),
         .row_o       (open_row_o[ROW_W*g +: ROW_W])
      );
      assign bank_state_o[3*g +: 3] = bank_st[g];
      assign bank_idle[g]           = (bank_st[g] == BS_IDLE);
   end

   logic            all_free, legal;
   logic [BA_W-1:0] first_bad, hit_bank;

   assign all_free = (&bank_idle) && !ref_busy;
   assign sel      = NUM_BANKS'(1) << bank_i;

   always_comb begin
      first_bad = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (!can_pre[i]) first_bad = BA_W'(i);
      end
   end

   always_comb begin
      legal    = 1'b1;
      hit_bank = bank_i;
      if (ref_busy && is_op) begin
         legal = 1'b0;
      end else begin
         unique case (cmd)
            CMD_ACT: legal = can_act[bank_i];
            CMD_RD,
            CMD_WR:  legal = can_rw[bank_i] && !(opt_bit && full_page);
            CMD_PRE: begin
               if (opt_bit) begin
                  legal    = &can_pre;
                  hit_bank = first_bad;
               end else begin
                  legal = can_pre[bank_i];
               end
            end
            CMD_REF,
            CMD_MRS: legal = all_free;
            default: legal = 1'b1;
         endcase
      end
   end

   assign act_v     = (legal && cmd == CMD_ACT) ? sel : '0;
   assign rd_v      = (legal && cmd == CMD_RD)  ? sel : '0;
   assign wr_v      = (legal && cmd == CMD_WR)  ? sel : '0;
   assign pre_v     = (legal && cmd == CMD_PRE) ? (opt_bit ? '1 : sel) : '0;
   assign ref_start = legal && (cmd == CMD_REF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         illegal_o      <= 1'b0;
         illegal_bank_o <= '0;
      end else begin
         illegal_o      <= !legal;
         illegal_bank_o <= hit_bank;
      end
   end

   assign all_idle_o = all_free;

   assert_flag_needs_command_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> $past(is_op));

   assert_refresh_blocks_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ref_busy && is_op) |=> illegal_o);

   assert_strobes_onehot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_v | rd_v | wr_v));

endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;

   localparam int NB    = 4;
   localparam int RW    = 12;
   localparam int T_RCD = 3;
   localparam int T_RP  = 3;
   localparam int T_RAS = 6;
   localparam int T_RC  = 9;
   localparam int T_WR  = 2;

   localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3,
                  C_PRE = 4, C_REF = 5, C_MRS = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]     bank_i = '0;
   logic [RW-1:0]  addr_i = '0;
   logic [2:0]     bl_code_i = '0;
   logic [3*NB-1:0]  bank_state_o;
   logic [RW*NB-1:0] open_row_o;
   logic           all_idle_o, illegal_o;
   logic [1:0]     illegal_bank_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   sdram_bank_tracker #(
      .NUM_BANKS(NB), .ROW_W(RW), .T_RCD(T_RCD), .T_RP(T_RP),
      .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .bank_i(bank_i), .addr_i(addr_i), .bl_code_i(bl_code_i),
      .bank_state_o(bank_state_o), .open_row_o(open_row_o),
      .all_idle_o(all_idle_o), .illegal_o(illegal_o),
      .illegal_bank_o(illegal_bank_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int st(input int b);
      return int'(bank_state_o[3*b +: 3]);
   endfunction

   // drive at a falling edge, let one rising edge sample it, return at the next falling edge
   task automatic issue(input int c, input int b, input bit a10, input int row);
      logic [2:0] pins;
      case (c)
         C_ACT:   pins = 3'b011;
         C_RD:    pins = 3'b101;
         C_WR:    pins = 3'b100;
         C_PRE:   pins = 3'b010;
         C_REF:   pins = 3'b001;
         C_MRS:   pins = 3'b000;
         default: pins = 3'b111;
      endcase
      cs_n   = (c == C_NOP);
      {ras_n, cas_n, we_n} = pins;
      bank_i = 2'(b);
      addr_i = RW'(row);
      if (c != C_ACT) addr_i[10] = a10;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0, 0);
   endtask

   task automatic settle_bank(input int b);
      nop(T_RC + T_RAS + 20);
      issue(C_PRE, b, 1'b0, 0);
      nop(T_RP + 2);
   endtask

   // activate, wait pad, auto-precharge access, wait k, probe activate
   task automatic run_ap(input bit wr, input int code, input int pad, input int k);
      int bl, dur, exp_ill;
      bl  = 1 << code;
      dur = wr ? (bl - 1 + T_WR + T_RP) : (bl + T_RP);
      exp_ill = !((pad + k + 2 >= T_RC) && (k + 1 >= dur));
      bl_code_i = 3'(code);
      issue(C_ACT, 1, 1'b0, 12'h123);
      nop(pad);
      issue(wr ? C_WR : C_RD, 1, 1'b1, 0);
      nop(k);
      issue(C_ACT, 1, 1'b0, 12'h321);
      if (wr) check("R6 write auto-precharge reopen", int'(illegal_o), exp_ill);
      else    check("R5 read auto-precharge reopen", int'(illegal_o), exp_ill);
      settle_bank(1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int b = 0; b < NB; b++) check("R1 reset state", st(b), 0);
      check("R1 reset all idle", int'(all_idle_o), 1);
      check("R1 reset flag", int'(illegal_o), 0);

      // R2 activate latches row and passes opening -> open
      issue(C_ACT, 2, 1'b0, 12'hABC);
      check("R2 act legal", int'(illegal_o), 0);
      check("R2 row latched", int'(open_row_o[RW*2 +: RW]), 12'hABC);
      nop(T_RCD - 2);
      check("R2 opening", st(2), 1);
      nop(1);
      check("R2 open", st(2), 2);
      check("R2 not all idle", int'(all_idle_o), 0);

      // R3 activate on open bank rejected, row kept
      issue(C_ACT, 2, 1'b0, 12'h555);
      check("R3 act on open bank", int'(illegal_o), 1);
      check("R3 bank index", int'(illegal_bank_o), 2);
      check("R3 row kept", int'(open_row_o[RW*2 +: RW]), 12'hABC);
      check("R3 state kept", st(2), 2);
      // R11 flag lasts one cycle
      nop(1);
      check("R11 pulse one cycle", int'(illegal_o), 0);
      settle_bank(2);
      check("R8 idle after precharge", st(2), 0);

      // R4 read/write versus T_RCD sweep
      for (int d = 0; d <= T_RCD; d++) begin
         issue(C_ACT, 0, 1'b0, d);
         nop(d);
         issue((d % 2) ? C_WR : C_RD, 0, 1'b0, 0);
         check("R4 access vs rcd", int'(illegal_o), (d + 1 < T_RCD) ? 1 : 0);
         if (d + 1 < T_RCD) check("R4 bank index", int'(illegal_bank_o), 0);
         settle_bank(0);
      end

      // R8 precharge versus T_RAS sweep
      for (int d = T_RAS - 3; d <= T_RAS; d++) begin
         issue(C_ACT, 3, 1'b0, 7);
         nop(d);
         issue(C_PRE, 3, 1'b0, 0);
         check("R8 precharge vs ras", int'(illegal_o), (d + 1 < T_RAS) ? 1 : 0);
         if (d + 1 >= T_RAS) begin
            check("R8 closing", st(3), 5);
            nop(T_RP - 1);
            check("R8 idle after rp", st(3), 0);
         end
         settle_bank(3);
      end

      // R5 / R6 auto-precharge sweeps over burst codes, with and without the T_RC bound
      for (int wr = 0; wr < 2; wr++) begin
         for (int code = 0; code < 4; code++) begin
            for (int p = 0; p < 2; p++) begin
               int bl, dur, pad;
               bl  = 1 << code;
               dur = wr ? (bl - 1 + T_WR + T_RP) : (bl + T_RP);
               pad = p ? T_RC : T_RCD - 1;
               for (int k = 0; k <= dur + 1; k++) run_ap(wr[0], code, pad, k);
            end
         end
      end

      // R8 plain read returns to open after BL; R7 full page
      bl_code_i = 3'd1;
      issue(C_ACT, 3, 1'b0, 1);
      nop(T_RC);
      issue(C_RD, 3, 1'b0, 0);
      check("R8 reading", st(3), 3);
      nop(1);
      check("R8 open after burst", st(3), 2);
      bl_code_i = 3'd7;
      issue(C_RD, 3, 1'b0, 0);
      nop(20);
      check("R7 full page stays reading", st(3), 3);
      issue(C_RD, 3, 1'b1, 0);
      check("R7 auto-precharge full page", int'(illegal_o), 1);
      check("R7 state kept", st(3), 3);
      issue(C_WR, 3, 1'b1, 0);
      check("R7 write auto-precharge full page", int'(illegal_o), 1);
      issue(C_PRE, 3, 1'b0, 0);
      check("R7 full page ended by precharge", st(3), 5);
      nop(T_RP - 1);
      check("R7 idle", st(3), 0);
      bl_code_i = 3'd2;
      nop(T_RC);

      // R9 precharge all
      issue(C_ACT, 0, 1'b0, 10);
      issue(C_ACT, 3, 1'b0, 11);
      nop(T_RC);
      issue(C_ACT, 1, 1'b0, 12);
      issue(C_PRE, 2, 1'b1, 0);
      check("R9 all-bank precharge rejected", int'(illegal_o), 1);
      check("R9 lowest offending bank", int'(illegal_bank_o), 1);
      check("R9 bank0 untouched", st(0), 2);
      nop(T_RC);
      issue(C_PRE, 2, 1'b1, 0);
      check("R9 all-bank precharge legal", int'(illegal_o), 0);
      check("R9 bank0 closing", st(0), 5);
      check("R9 bank1 closing", st(1), 5);
      check("R9 bank2 idle", st(2), 0);
      check("R9 bank3 closing", st(3), 5);
      nop(T_RP - 1);
      check("R9 all idle after rp", int'(all_idle_o), 1);
      nop(T_RC);

      // R10 refresh and mode set
      issue(C_ACT, 0, 1'b0, 3);
      issue(C_REF, 0, 1'b0, 0);
      check("R10 refresh with open bank", int'(illegal_o), 1);
      issue(C_MRS, 2, 1'b0, 0);
      check("R10 mode set with open bank", int'(illegal_o), 1);
      check("R10 mode set bank index", int'(illegal_bank_o), 2);
      settle_bank(0);
      issue(C_MRS, 0, 1'b0, 0);
      check("R10 mode set when idle", int'(illegal_o), 0);
      issue(C_REF, 0, 1'b0, 0);
      check("R10 refresh when idle", int'(illegal_o), 0);
      check("R10 busy after refresh", int'(all_idle_o), 0);
      nop(T_RC - 2);
      issue(C_ACT, 0, 1'b0, 4);
      check("R10 command inside rc", int'(illegal_o), 1);
      check("R10 bank state kept", st(0), 0);
      issue(C_ACT, 0, 1'b0, 4);
      check("R10 command after rc", int'(illegal_o), 0);
      nop(1);
      check("R11 no flag on nop", int'(illegal_o), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule